// File: doc/BRIEF.md
# Station Cipher Key Table

This block keeps one cipher key record per station in a table of 128 entries. Software fills the table through a 32-bit register bus. Each entry is seen on that bus as eight word registers: five key words, one cipher-type word and two station-address words. The second address word also carries the entry's valid flag. The receive and transmit datapaths query the table with a 48-bit station address. One cycle later they get a hit flag, the index of the matching entry, its cipher type and its 128-bit key.

The first four key words are kept as two wide storage rows. Each row pairs an even word with the odd word after it. An even-word write is parked in a single holding register, and the row is written only when the odd word arrives. The station address is kept with its least significant bit dropped, so bit 0 of a looked-up address never takes part in the comparison.

Top module: `keytab_top`

## Requirements
- R1: The word address is `{entry[7:0], sel[2:0]}`. An entry field of 128 or more is out of range: writes there change no state, and reads return 0.
- R2: The register select codes are 0 KEY0, 1 KEY1, 2 KEY2, 3 KEY3, 4 KEY4, 5 TYPE, 6 MAC0 and 7 MAC1. Each register reads back what was committed to it.
- R3: A write to KEY0 or KEY2 only loads the holding register. A write to KEY1 commits `{wdata[15:0], held}` to the KEY0/KEY1 row, and a write to KEY3 commits it to the KEY2/KEY3 row. The held value is the most recent even-word write to any entry.
- R4: KEY1 and KEY3 keep 16 bits and read back with the upper 16 bits zero. KEY4 keeps all 32 bits. In a lookup result, KEY4 is cut to its low 8 bits when the type is 40-bit or 104-bit.
- R5: MAC0 holds address bits 32:1. MAC1 bits 14:0 hold address bits 47:33 and MAC1 bit 15 is the valid flag. MAC1 reads back as `{16'b0, valid, bits 47:33}`.
- R6: A lookup compares `lk_addr[47:1]` against every valid entry and reports the lowest matching index. `lk_done` rises one cycle after `lk_req`, with the results.
- R7: TYPE bits 2:0 encode the cipher: 0 is 40-bit, 1 is 104-bit, 3 is 128-bit, 5 is AES and 7 is clear. A register read returns the stored 3 bits with the upper bits zero. A lookup reports any other code as 7.
- R8: On a miss, the lookup reports hit 0, index 0, type 7 and key 0.
- R9: Writing zero to all eight registers of an entry leaves it invalid, so lookups no longer match it.
- R10: `bus_rvalid` rises one cycle after `bus_re`, with `bus_rdata`.
- R11: Reset clears every valid flag, every stored address and the holding register.
- R12: A lookup in the same cycle as a table write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | Word address {entry, sel} |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 48 | Station address to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A valid entry matched |
| lk_idx | output | 7 | Lowest matching entry index |
| lk_type | output | 3 | Normalised cipher type |
| lk_key | output | 128 | {KEY4, KEY3[15:0], KEY2, KEY1[15:0], KEY0} |

## Verification
The assertions check the following on every cycle:
- The strobe-to-valid latencies of the lookup port and the read port.
- Reported matches only ever point at valid entries.
- A miss always carries the zero/clear result.
- Short keys have their upper KEY4 bits cut off.
- An out-of-range write leaves the valid flags alone.
- A MAC1 write sets the valid flag from bit 15.

Some behaviours need the bench's scenarios, where a behavioural model is compared every clock:
- The lowest-index priority between duplicate addresses.
- The even/odd pairing, including an odd write with no partner.
- Readback masking and the normalisation of unknown types.
- The same-cycle ordering of a write against a lookup.

// File: rtl/kt_pkg.sv
package kt_pkg;

  localparam int unsigned SEL_W     = 3;
  localparam int unsigned VALID_BIT = 15;

  typedef enum logic [SEL_W-1:0] {
    SEL_KEY0 = 3'd0,
    SEL_KEY1 = 3'd1,
    SEL_KEY2 = 3'd2,
    SEL_KEY3 = 3'd3,
    SEL_KEY4 = 3'd4,
    SEL_TYPE = 3'd5,
    SEL_MAC0 = 3'd6,
    SEL_MAC1 = 3'd7
  } kt_sel_e;

  typedef enum logic [2:0] {
    CT_W40  = 3'd0,
    CT_W104 = 3'd1,
    CT_W128 = 3'd3,
    CT_AES  = 3'd5,
    CT_NONE = 3'd7
  } kt_ctype_e;

  function automatic logic [2:0] kt_norm_type(input logic [2:0] raw);
    case (raw)
      3'd0, 3'd1, 3'd3, 3'd5, 3'd7: kt_norm_type = raw;
      default:                      kt_norm_type = CT_NONE;
    endcase
  endfunction

  function automatic logic kt_short_key(input logic [2:0] raw);
    kt_short_key = (raw == CT_W40) || (raw == CT_W104);
  endfunction

endpackage

// File: rtl/kt_ram.sv
module kt_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  qa,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  qb
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (ra_en) qa <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    if (rb_en) qb <= mem[rb_addr];
  end

endmodule

// File: rtl/kt_pair_stage.sv
module kt_pair_stage
  import kt_pkg::*;
#(
  parameter int NROWS = 2,
  parameter int LO_W  = 32,
  parameter int HI_W  = 16,
  localparam int ROW_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  kt_sel_e          sel,
  input  logic [31:0]      wdata,
  output logic [NROWS-1:0] row_we,
  output logic [ROW_W-1:0] row_data
);

  logic [LO_W-1:0]  hold_q;
  logic [NROWS-1:0] even_hit;

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign even_hit[r] = wr_ok && (sel == kt_sel_e'(2*r));
    assign row_we[r]   = wr_ok && (sel == kt_sel_e'(2*r + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (|even_hit) begin
      hold_q <= wdata[LO_W-1:0];
    end
  end

  assign row_data = {wdata[HI_W-1:0], hold_q};

  // R3: an even write parks its data for the next odd commit
  a_r3_hold_capture: assert property (@(posedge clk) disable iff (rst)
    (|even_hit) |=> (row_data[LO_W-1:0] == $past(wdata[LO_W-1:0])));

endmodule

// File: rtl/kt_cam.sv
module kt_cam
  import kt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LO_W  = 32,
  parameter int HI_W  = 15,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int KEY_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [KEY_W-1:0] match_key,
  output logic             match_hit,
  output logic [IDX_W-1:0] match_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LO_W-1:0]  rd_lo,
  output logic [HI_W-1:0]  rd_hi,
  output logic             rd_valid,
  output logic [DEPTH-1:0] valid_o
);

  logic [LO_W-1:0]  lo_q [DEPTH];
  logic [HI_W-1:0]  hi_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else begin
      if (lo_we) lo_q[widx] <= wdata[LO_W-1:0];
      if (hi_we) begin
        hi_q[widx]    <= wdata[HI_W-1:0];
        valid_q[widx] <= wdata[VALID_BIT];
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign eq[e] = valid_q[e] && ({hi_q[e], lo_q[e]} == match_key);
  end

  always_comb begin
    match_hit = 1'b0;
    match_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) begin
        match_hit = 1'b1;
        match_idx = IDX_W'(i);
      end
    end
  end

  assign rd_lo    = lo_q[rd_idx];
  assign rd_hi    = hi_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign valid_o  = valid_q;

  // R6: a reported match always names a valid entry
  a_r6_hit_is_valid: assert property (@(posedge clk) disable iff (rst)
    match_hit |-> valid_q[match_idx]);

  // R5: MAC1 bit 15 becomes the entry's valid flag
  a_r5_valid_from_mac1: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> (valid_q[$past(widx)] == $past(wdata[VALID_BIT])));

endmodule

// File: rtl/keytab_top.sv
module keytab_top
  import kt_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = IDX_W + 1 + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              lk_req,
  input  logic [47:0]       lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [2:0]        lk_type,
  output logic [127:0]      lk_key
);

  localparam int LO_W   = 32;
  localparam int HI_W   = 16;
  localparam int ROW_W  = LO_W + HI_W;
  localparam int MHI_W  = 15;
  localparam int EF_W   = IDX_W + 1;

  kt_sel_e          sel;
  logic [EF_W-1:0]  ent_f;
  logic             in_rng;
  logic [IDX_W-1:0] ent;
  logic             wr_ok;
  logic             unused_lsb;

  assign sel        = kt_sel_e'(bus_addr[SEL_W-1:0]);
  assign ent_f      = bus_addr[ADDR_W-1:SEL_W];
  assign in_rng     = (ent_f < EF_W'(ENTRIES));
  assign ent        = ent_f[IDX_W-1:0];
  assign wr_ok      = bus_we && in_rng;
  assign unused_lsb = lk_addr[0];

  // even/odd row commit
  logic [1:0]       row_we;
  logic [ROW_W-1:0] row_data;

  kt_pair_stage #(.NROWS(2), .LO_W(LO_W), .HI_W(HI_W)) pair_i (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .sel      (sel),
    .wdata    (bus_wdata),
    .row_we   (row_we),
    .row_data (row_data)
  );

  // station address match array
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic [LO_W-1:0]  c_lo;
  logic [MHI_W-1:0] c_hi;
  logic             c_v;
  logic [ENTRIES-1:0] valid_vec;

  kt_cam #(.DEPTH(ENTRIES), .LO_W(LO_W), .HI_W(MHI_W)) cam_i (
    .clk       (clk),
    .rst       (rst),
    .lo_we     (wr_ok && sel == SEL_MAC0),
    .hi_we     (wr_ok && sel == SEL_MAC1),
    .widx      (ent),
    .wdata     (bus_wdata),
    .match_key (lk_addr[47:1]),
    .match_hit (m_hit),
    .match_idx (m_idx),
    .rd_idx    (ent),
    .rd_lo     (c_lo),
    .rd_hi     (c_hi),
    .rd_valid  (c_v),
    .valid_o   (valid_vec)
  );

  // key and type storage
  logic [ROW_W-1:0] rowa_qa, rowa_qb, rowb_qa, rowb_qb;
  logic [31:0]      k4_qa, k4_qb;
  logic [2:0]       ty_qa, ty_qb;

  kt_ram #(.W(ROW_W), .DEPTH(ENTRIES)) rowa_i (
    .clk(clk), .we(row_we[0]), .waddr(ent), .wdata(row_data),
    .ra_en(lk_req), .ra_addr(m_idx), .qa(rowa_qa),
    .rb_en(bus_re), .rb_addr(ent), .qb(rowa_qb)
  );

  kt_ram #(.W(ROW_W), .DEPTH(ENTRIES)) rowb_i (
    .clk(clk), .we(row_we[1]), .waddr(ent), .wdata(row_data),
    .ra_en(lk_req), .ra_addr(m_idx), .qa(rowb_qa),
    .rb_en(bus_re), .rb_addr(ent), .qb(rowb_qb)
  );

  kt_ram #(.W(32), .DEPTH(ENTRIES)) key4_i (
    .clk(clk), .we(wr_ok && sel == SEL_KEY4), .waddr(ent), .wdata(bus_wdata),
    .ra_en(lk_req), .ra_addr(m_idx), .qa(k4_qa),
    .rb_en(bus_re), .rb_addr(ent), .qb(k4_qb)
  );

  kt_ram #(.W(3), .DEPTH(ENTRIES)) type_i (
    .clk(clk), .we(wr_ok && sel == SEL_TYPE), .waddr(ent), .wdata(bus_wdata[2:0]),
    .ra_en(lk_req), .ra_addr(m_idx), .qa(ty_qa),
    .rb_en(bus_re), .rb_addr(ent), .qb(ty_qb)
  );

  // bus read path
  logic             rv_q;
  kt_sel_e          rsel_q;
  logic             rin_q;
  logic [LO_W-1:0]  rlo_q;
  logic [MHI_W-1:0] rhi_q;
  logic             rvld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q   <= 1'b0;
      rsel_q <= SEL_KEY0;
      rin_q  <= 1'b0;
      rlo_q  <= '0;
      rhi_q  <= '0;
      rvld_q <= 1'b0;
    end else begin
      rv_q <= bus_re;
      if (bus_re) begin
        rsel_q <= sel;
        rin_q  <= in_rng;
        rlo_q  <= c_lo;
        rhi_q  <= c_hi;
        rvld_q <= c_v;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rin_q) begin
      case (rsel_q)
        SEL_KEY0: bus_rdata = rowa_qb[LO_W-1:0];
        SEL_KEY1: bus_rdata = {16'b0, rowa_qb[ROW_W-1:LO_W]};
        SEL_KEY2: bus_rdata = rowb_qb[LO_W-1:0];
        SEL_KEY3: bus_rdata = {16'b0, rowb_qb[ROW_W-1:LO_W]};
        SEL_KEY4: bus_rdata = k4_qb;
        SEL_TYPE: bus_rdata = {29'b0, ty_qb};
        SEL_MAC0: bus_rdata = rlo_q;
        SEL_MAC1: bus_rdata = {16'b0, rvld_q, rhi_q};
        default:  bus_rdata = '0;
      endcase
    end
  end
  assign bus_rvalid = rv_q;

  // lookup result path
  logic             ld_q;
  logic             hit_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      k4_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q  <= 1'b0;
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      ld_q <= lk_req;
      if (lk_req) begin
        hit_q <= m_hit;
        idx_q <= m_hit ? m_idx : '0;
      end
    end
  end

  assign k4_eff  = kt_short_key(ty_qa) ? {24'b0, k4_qa[7:0]} : k4_qa;
  assign lk_done = ld_q;
  assign lk_hit  = hit_q;
  assign lk_idx  = idx_q;
  assign lk_type = hit_q ? kt_norm_type(ty_qa) : CT_NONE;
  assign lk_key  = hit_q ? {k4_eff, rowb_qa, rowa_qa} : '0;

  // R1: an out-of-range write leaves all valid flags untouched
  a_r1_oor_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !in_rng) |=> $stable(valid_vec));

  // R1: an out-of-range read returns zero
  a_r1_oor_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !in_rng) |=> (bus_rdata == 32'd0));

  // R6: lookup result one cycle after request
  a_r6_done_latency: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_done);

  a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_done);

  // R8: a miss carries the zero/clear result
  a_r8_miss_result: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> (lk_key == '0 && lk_type == CT_NONE && lk_idx == '0));

  // R4: short keys report only eight KEY4 bits
  a_r4_short_key4: assert property (@(posedge clk) disable iff (rst)
    (lk_done && lk_hit && (lk_type == CT_W40 || lk_type == CT_W104))
      |-> (lk_key[127:104] == '0));

  // R10: read data valid one cycle after the strobe
  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid);

endmodule

// File: tb/keytab_top_tb_top.sv
`timescale 1ns/1ps
module keytab_top_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [10:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic         lk_req = 1'b0;
  logic [47:0]  lk_addr = '0;
  logic         lk_done;
  logic         lk_hit;
  logic [6:0]   lk_idx;
  logic [2:0]   lk_type;
  logic [127:0] lk_key;

  always #2 clk = ~clk;

  keytab_top dut_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_type(lk_type), .lk_key(lk_key)
  );

  // behavioural reference model
  logic [31:0] m_k0 [128];
  logic [15:0] m_k1 [128];
  logic [31:0] m_k2 [128];
  logic [15:0] m_k3 [128];
  logic [31:0] m_k4 [128];
  logic [2:0]  m_ty [128];
  logic [31:0] m_lo [128];
  logic [14:0] m_hi [128];
  logic        m_v  [128];
  logic [31:0] m_hold;

  logic         exp_rv, exp_ld, exp_hit;
  logic [31:0]  exp_rd;
  logic [6:0]   exp_idx;
  logic [2:0]   exp_ty;
  logic [127:0] exp_key;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    finished = 0;
  string cur_tag = "R11";

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_k0[i] = '0; m_k1[i] = '0; m_k2[i] = '0; m_k3[i] = '0;
      m_k4[i] = '0; m_ty[i] = '0; m_lo[i] = '0; m_hi[i] = '0; m_v[i] = 1'b0;
    end
    m_hold = '0;
  end

  function automatic logic [31:0] mread(input int e, input int s);
    if (e >= 128) return 32'd0;
    case (s)
      0: return m_k0[e];
      1: return {16'd0, m_k1[e]};
      2: return m_k2[e];
      3: return {16'd0, m_k3[e]};
      4: return m_k4[e];
      5: return {29'd0, m_ty[e]};
      6: return m_lo[e];
      default: return {16'd0, m_v[e], m_hi[e]};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) begin
        m_v[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0;
      end
      m_hold = '0;
      exp_rv = 1'b0;
      exp_ld = 1'b0;
    end else begin
      int e, s;
      e = int'(bus_addr[10:3]);
      s = int'(bus_addr[2:0]);
      exp_rv = bus_re;
      if (bus_re) exp_rd = mread(e, s);
      exp_ld = lk_req;
      if (lk_req) begin
        exp_hit = 1'b0; exp_idx = '0; exp_ty = 3'd7; exp_key = '0;
        for (int i = 0; i < 128; i++) begin
          if (!exp_hit && m_v[i] && {m_hi[i], m_lo[i]} == lk_addr[47:1]) begin
            logic [31:0] k4;
            exp_hit = 1'b1;
            exp_idx = 7'(i);
            case (m_ty[i])
              3'd0, 3'd1, 3'd3, 3'd5, 3'd7: exp_ty = m_ty[i];
              default: exp_ty = 3'd7;
            endcase
            k4 = (m_ty[i] == 3'd0 || m_ty[i] == 3'd1) ? (m_k4[i] & 32'hFF) : m_k4[i];
            exp_key = {k4, m_k3[i], m_k2[i], m_k1[i], m_k0[i]};
          end
        end
      end
      if (bus_we && e < 128) begin
        case (s)
          0, 2: m_hold = bus_wdata;
          1: begin m_k0[e] = m_hold; m_k1[e] = bus_wdata[15:0]; end
          3: begin m_k2[e] = m_hold; m_k3[e] = bus_wdata[15:0]; end
          4: m_k4[e] = bus_wdata;
          5: m_ty[e] = bus_wdata[2:0];
          6: m_lo[e] = bus_wdata;
          default: begin m_hi[e] = bus_wdata[14:0]; m_v[e] = bus_wdata[15]; end
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      n_cmp++;
      if (bus_rvalid !== exp_rv || lk_done !== exp_ld) begin
        n_bad++;
        $display("FAIL %s strobes: rvalid=%0b done=%0b expected rvalid=%0b done=%0b",
                 cur_tag, bus_rvalid, lk_done, exp_rv, exp_ld);
      end
      if (exp_rv) begin
        n_cmp++;
        if (bus_rdata !== exp_rd) begin
          n_bad++;
          $display("FAIL %s read: got %h expected %h", cur_tag, bus_rdata, exp_rd);
        end
      end
      if (exp_ld) begin
        n_cmp++;
        if (lk_hit !== exp_hit || lk_idx !== exp_idx || lk_type !== exp_ty || lk_key !== exp_key) begin
          n_bad++;
          $display("FAIL %s lookup: got hit=%0b idx=%0d ty=%0d key=%h expected hit=%0b idx=%0d ty=%0d key=%h",
                   cur_tag, lk_hit, lk_idx, lk_type, lk_key, exp_hit, exp_idx, exp_ty, exp_key);
        end
      end
    end
  end

  task automatic wr(input int e, input int s, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = {e[7:0], s[2:0]}; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int e, input int s);
    bus_re = 1'b1; bus_addr = {e[7:0], s[2:0]};
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic lk(input logic [47:0] a);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic wr_lk(input int e, input int s, input logic [31:0] d, input logic [47:0] a);
    bus_we = 1'b1; bus_addr = {e[7:0], s[2:0]}; bus_wdata = d;
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    bus_we = 1'b0; lk_req = 1'b0;
  endtask

  task automatic set_mac(input int e, input logic [47:0] a, input logic v);
    wr(e, 6, a[32:1]);
    wr(e, 7, {16'd0, v, a[47:33]});
  endtask

  task automatic set_key(input int e, input logic [31:0] k0, input logic [31:0] k1,
                         input logic [31:0] k2, input logic [31:0] k3,
                         input logic [31:0] k4, input logic [2:0] ty);
    wr(e, 0, k0); wr(e, 1, k1); wr(e, 2, k2); wr(e, 3, k3);
    wr(e, 4, k4); wr(e, 5, {29'd0, ty});
  endtask

  localparam logic [47:0] MAC_A = 48'h1234_5678_9ABC;
  localparam logic [47:0] MAC_B = 48'h0A0B_0C0D_0E0E;
  localparam logic [47:0] MAC_C = 48'hC0FF_EE00_1122;
  localparam logic [47:0] MAC_D = 48'h7777_6666_5554;
  localparam logic [47:0] MAC_E = 48'h0102_0304_0506;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11: reset state, holding register reset to zero
    cur_tag = "R11";
    lk(MAC_A);
    rd(0, 7);
    wr(5, 1, 32'hABCD_1234);
    rd(5, 0);
    rd(5, 1);

    // R9: clear every entry by zero writes
    cur_tag = "R9";
    for (int e = 0; e < 128; e++)
      for (int s = 0; s < 8; s++) wr(e, s, 32'd0);
    lk(MAC_A);

    // R2: full entry write and readback of every register
    cur_tag = "R2";
    set_key(3, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888, 32'h99AA_BBCC, 3'd3);
    set_mac(3, MAC_A, 1'b1);
    for (int s = 0; s < 8; s++) rd(3, s);

    // R5: address compare ignores bit 0
    cur_tag = "R5";
    lk(MAC_A);
    lk(MAC_A ^ 48'h1);
    lk(MAC_A ^ 48'h2);

    // R3: even/odd pairing
    cur_tag = "R3";
    wr(3, 0, 32'hFACE_0001);
    rd(3, 0);
    wr(3, 1, 32'h0000_BEEF);
    rd(3, 0);
    wr(3, 2, 32'h0BAD_0BAD);
    wr(7, 0, 32'h5A5A_A5A5);
    wr(3, 3, 32'h0000_1357);
    rd(3, 2);
    rd(3, 3);

    // R4: field widths and short-key masking
    cur_tag = "R4";
    wr(3, 1, 32'hFFFF_FFFF);
    rd(3, 1);
    set_key(9, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 32'hC1C2_C3C4, 32'hD1D2_D3D4, 32'hDEAD_BEEF, 3'd1);
    set_mac(9, MAC_B, 1'b1);
    lk(MAC_B);
    rd(9, 4);
    wr(9, 5, 32'd0);
    lk(MAC_B);

    // R6: lowest matching valid index wins
    cur_tag = "R6";
    set_mac(20, MAC_C, 1'b1);
    set_mac(12, MAC_C, 1'b1);
    set_key(12, 32'h0C0C_0C0C, 32'h0000_1212, 32'h2222_1212, 32'h0000_3434, 32'h4545_5656, 3'd5);
    lk(MAC_C);
    set_mac(12, MAC_C, 1'b0);
    set_mac(6, MAC_C, 1'b0);
    lk(MAC_C);

    // R7: type readback raw, lookup normalised
    cur_tag = "R7";
    wr(20, 5, 32'hFFFF_FFFE);
    rd(20, 5);
    lk(MAC_C);

    // R8: miss result
    cur_tag = "R8";
    lk(48'hFFFF_FFFF_FFFF);

    // R1: out-of-range entry index is ignored
    cur_tag = "R1";
    set_mac(130, MAC_D, 1'b1);
    wr(130, 0, 32'h1234_0000);
    wr(130, 1, 32'h0000_5678);
    lk(MAC_D);
    rd(130, 7);
    rd(2, 7);
    rd(2, 0);

    // R12: lookup sees the table before a same-cycle write
    cur_tag = "R12";
    wr(30, 6, MAC_E[32:1]);
    wr_lk(30, 7, {16'd0, 1'b1, MAC_E[47:33]}, MAC_E);
    lk(MAC_E);

    // R10: back-to-back reads
    cur_tag = "R10";
    rd(3, 6);
    rd(3, 7);
    rd(9, 0);

    // R9: clearing a live entry removes it from lookups
    cur_tag = "R9";
    for (int s = 0; s < 8; s++) wr(3, s, 32'd0);
    lk(MAC_A);
    rd(3, 7);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule